// File: doc/BRIEF.md
# Vector Register Group Sequencer

This block sits between instruction issue and the vector datapath. It takes one vector instruction that names a destination register and two source registers, together with the runtime length multiplier. The multiplier says how many physical registers each named register stands for. The block expands the instruction into a stream of per-register micro-operations. Each micro-operation names the physical destination and the two physical sources for one slice of the register group. It issues at most one per cycle and respects backpressure from the consumer.

A register index under a multiplier of N must be a multiple of N, because it names an aligned group of N consecutive registers out of 32. An instruction that breaks this rule is reported as illegal and produces no micro-operations. Alongside the stream, the block reports how many elements one register holds at the current element width. That count is the register width divided by the element width.

Top module: `vgs_top`

## Requirements
- R1: After reset, `uop_valid` and `illegal` are 0, `in_ready` is 1, and `elems_per_reg` equals VLEN/8.
- R2: A legal instruction accepted in one cycle (`in_valid` and `in_ready` both high) presents its first micro-operation in the next cycle. Multiplier code 0, 1, 2 and 3 gives 1, 2, 4 and 8 micro-operations.
- R3: Micro-operation k (counting from 0) names destination `vd+k`, first source `vs1+k` and second source `vs2+k`.
- R4: If any of the three indices is not a multiple of the group size, `illegal` is high for exactly the cycle after acceptance. No micro-operation is issued, and `elems_per_reg` keeps its previous value.
- R5: `uop_last` is high on micro-operation k = group size − 1 and on no other. After that micro-operation is handed off, `uop_valid` is low in the next cycle.
- R6: While `uop_valid` is high and `uop_ready` is low, the presented micro-operation stays unchanged and the slice does not advance.
- R7: `in_ready` is low from the cycle after a legal acceptance until the last micro-operation has been handed off. It is high again in the following cycle.
- R8: Element width code 0, 1, 2 and 3 selects 8, 16, 32 and 64 bits. From the cycle after a legal instruction is accepted, `elems_per_reg` equals VLEN divided by that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| in_vd | input | 5 | Destination register index |
| in_vs1 | input | 5 | First source register index |
| in_vs2 | input | 5 | Second source register index |
| in_mult | input | 2 | Multiplier code (1, 2, 4, 8) |
| in_width | input | 2 | Element width code (8, 16, 32, 64) |
| uop_valid | output | 1 | Micro-operation presented |
| uop_ready | input | 1 | Consumer takes the micro-operation |
| uop_vd | output | 5 | Physical destination of the slice |
| uop_vs1 | output | 5 | Physical first source of the slice |
| uop_vs2 | output | 5 | Physical second source of the slice |
| uop_last | output | 1 | Final slice of the group |
| illegal | output | 1 | One-cycle flag for a misaligned instruction |
| elems_per_reg | output | 7 | Elements held by one register at the latched width |

## Verification
The assertions assume the instruction is offered only while `in_ready` is high, so they never see an offer during a sweep. The stimulus keeps to this by driving `in_valid` for exactly one cycle from the idle state and then waiting until the sweep has drained. The assertions also assume `uop_ready` may toggle freely. The bench draws `uop_ready` at random each cycle so that stalls fall on first, middle and last slices. The bench mixes aligned and deliberately misaligned indices across all multiplier and width codes.

// File: rtl/vgs_pkg.sv
// Shared encodings for the vector register group sequencer.
// Assumes 2-bit codes for both the multiplier and the element width.
package vgs_pkg;

    // Length multiplier code: group of 1, 2, 4 or 8 physical registers
    typedef enum logic [1:0] {
        GRP1 = 2'd0,
        GRP2 = 2'd1,
        GRP4 = 2'd2,
        GRP8 = 2'd3
    } grp_code_e;

    // Element width code: 8, 16, 32 or 64 bits
    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } ew_code_e;

    localparam int unsigned MAX_GROUP = 8;
    localparam int unsigned SLICE_W   = 3;

    // Mask of index bits that must be zero for an aligned group
    function automatic logic [SLICE_W-1:0] align_mask(input grp_code_e code);
        return SLICE_W'((1 << code) - 1);
    endfunction

endpackage

// File: rtl/vgs_align_check.sv
// Checks that each operand index names an aligned register group.
// Assumes the group size is a power of two no larger than MAX_GROUP.
module vgs_align_check
    import vgs_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned N_OPND = 3
) (
    input  logic [N_OPND-1:0][IDX_W-1:0] idx,
    input  grp_code_e                    grp,
    output logic                         aligned,
    output logic [SLICE_W-1:0]           last_slice
);

    logic [SLICE_W-1:0] mask;
    logic [N_OPND-1:0]  opnd_ok;

    // Derive the group mask and the index of the final slice
    always_comb begin
        mask       = align_mask(grp);
        last_slice = mask;
    end

    // One alignment test per operand
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        always_comb opnd_ok[g] = ((idx[g][SLICE_W-1:0] & mask) == '0);
    end

    // The instruction is legal only if every operand is aligned
    always_comb aligned = &opnd_ok;

endmodule

// File: rtl/vgs_elem_count.sv
// Converts an element width code into the element count of one register.
// Assumes VLEN is a power of two of at least 64.
module vgs_elem_count
    import vgs_pkg::*;
#(
    parameter int unsigned VLEN   = 512,
    parameter int unsigned CNT_W  = $clog2(VLEN / 8) + 1
) (
    input  ew_code_e         ew,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] BYTE_ELEMS = CNT_W'(VLEN / 8);

    // Each step up in width halves the element count
    always_comb count = BYTE_ELEMS >> ew;

endmodule

// File: rtl/vgs_slice_ctrl.sv
// Sweep controller: holds the busy state and the current slice number.
// Assumes start is raised only while the controller is idle.
module vgs_slice_ctrl
    import vgs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SLICE_W-1:0] last_slice_in,
    input  logic               out_ready,
    output logic               busy,
    output logic [SLICE_W-1:0] slice,
    output logic               last
);

    logic [SLICE_W-1:0] last_slice_q;

    // Advance the slice on each hand-off and leave after the final one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            slice        <= '0;
            last_slice_q <= '0;
        end else if (start) begin
            busy         <= 1'b1;
            slice        <= '0;
            last_slice_q <= last_slice_in;
        end else if (busy && out_ready) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                slice <= slice + 1'b1;
            end
        end
    end

    // Flag the final slice of the group
    always_comb last = busy && (slice == last_slice_q);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !out_ready |=> busy && $stable(slice)); // R6
    AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && out_ready && last |=> !busy); // R5
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R7

endmodule

// File: rtl/vgs_top.sv
// Vector register group sequencer top. It accepts one instruction at a
// time and sweeps its register group as one micro-operation per cycle.
// It flags misaligned groups and reports elements per register.
// Assumes in_valid is offered only while in_ready is high.
module vgs_top
    import vgs_pkg::*;
#(
    parameter int unsigned VLEN   = 512,
    parameter int unsigned NREGS  = 32,
    parameter int unsigned IDX_W  = $clog2(NREGS),
    parameter int unsigned CNT_W  = $clog2(VLEN / 8) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_vd,
    input  logic [IDX_W-1:0] in_vs1,
    input  logic [IDX_W-1:0] in_vs2,
    input  logic [1:0]       in_mult,
    input  logic [1:0]       in_width,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [IDX_W-1:0] uop_vd,
    output logic [IDX_W-1:0] uop_vs1,
    output logic [IDX_W-1:0] uop_vs2,
    output logic             uop_last,
    output logic             illegal,
    output logic [CNT_W-1:0] elems_per_reg
);

    localparam int unsigned N_OPND = 3;

    logic [N_OPND-1:0][IDX_W-1:0] in_idx;
    logic [N_OPND-1:0][IDX_W-1:0] base_q;
    logic [N_OPND-1:0][IDX_W-1:0] phys;
    logic                         accept;
    logic                         aligned;
    logic [SLICE_W-1:0]           last_slice;
    logic                         start;
    logic                         busy;
    logic [SLICE_W-1:0]           slice;
    logic                         last;
    ew_code_e                     ew_q;

    // Pack the operand indices for the shared per-operand logic
    always_comb in_idx = {in_vs2, in_vs1, in_vd};

    // Handshake on the instruction side
    always_comb begin
        in_ready = !busy;
        accept   = in_valid && in_ready;
        start    = accept && aligned;
    end

    vgs_align_check #(.IDX_W(IDX_W), .N_OPND(N_OPND)) u_align (
        .idx        (in_idx),
        .grp        (grp_code_e'(in_mult)),
        .aligned    (aligned),
        .last_slice (last_slice)
    );

    vgs_slice_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .last_slice_in (last_slice),
        .out_ready     (uop_ready),
        .busy          (busy),
        .slice         (slice),
        .last          (last)
    );

    vgs_elem_count #(.VLEN(VLEN), .CNT_W(CNT_W)) u_elems (
        .ew    (ew_q),
        .count (elems_per_reg)
    );

    // Latch the base indices and width of a legal instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ew_q   <= EW8;
        end else if (start) begin
            base_q <= in_idx;
            ew_q   <= ew_code_e'(in_width);
        end
    end

    // Raise the illegal flag for one cycle after a misaligned acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) illegal <= 1'b0;
        else        illegal <= accept && !aligned;
    end

    // Physical register of each operand for the current slice
    for (genvar g = 0; g < N_OPND; g++) begin : g_phys
        always_comb phys[g] = base_q[g] + IDX_W'(slice);
    end

    // Drive the micro-operation port
    always_comb begin
        uop_valid = busy;
        uop_vd    = phys[0];
        uop_vs1   = phys[1];
        uop_vs2   = phys[2];
        uop_last  = last;
    end

    AST_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> uop_valid); // R2
    AST_SLICE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && !uop_last |=>
            uop_valid && (uop_vd == IDX_W'($past(uop_vd) + 1'b1))
                      && (uop_vs1 == IDX_W'($past(uop_vs1) + 1'b1))); // R3
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=>
            $stable(uop_vd) && $stable(uop_vs2) && $stable(uop_last)); // R6
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !uop_valid && in_ready); // R4
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !in_ready); // R7

endmodule

// File: tb/tb_vgs_top.sv
// Self-checking bench for the vector register group sequencer.
module tb_vgs_top;

    localparam int VLEN = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [4:0] in_vd = '0, in_vs1 = '0, in_vs2 = '0;
    logic [1:0] in_mult = '0, in_width = '0;
    logic       uop_valid;
    logic       uop_ready = 1'b0;
    logic [4:0] uop_vd, uop_vs1, uop_vs2;
    logic       uop_last;
    logic       illegal;
    logic [6:0] elems_per_reg;

    int checks = 0;
    int failures = 0;
    int exp_elems = VLEN / 8;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vgs_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_vd(in_vd), .in_vs1(in_vs1), .in_vs2(in_vs2),
        .in_mult(in_mult), .in_width(in_width),
        .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_vd(uop_vd), .uop_vs1(uop_vs1), .uop_vs2(uop_vs2),
        .uop_last(uop_last), .illegal(illegal), .elems_per_reg(elems_per_reg)
    );

    function automatic int calc_elems(input int w);
        return VLEN / (8 << w);
    endfunction

    function automatic bit calc_legal(input int vd, input int a, input int b, input int m);
        int n = 1 << m;
        return (vd % n == 0) && (a % n == 0) && (b % n == 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one instruction, then follow its sweep with random backpressure
    task automatic run_instr(input int vd, input int a, input int b, input int m,
                             input int w, input int ready_pct);
        int n = 1 << m;
        int k = 0;
        int guard = 0;
        bit legal = calc_legal(vd, a, b, m);
        @(negedge clk);
        chk(in_ready == 1'b1, "R7 idle ready", in_ready, 1);
        in_valid = 1'b1; in_vd = 5'(vd); in_vs1 = 5'(a); in_vs2 = 5'(b);
        in_mult = 2'(m); in_width = 2'(w);
        @(negedge clk);
        in_valid = 1'b0;
        if (!legal) begin
            chk(illegal == 1'b1, "R4 illegal flag", illegal, 1);
            chk(uop_valid == 1'b0, "R4 no uop", uop_valid, 0);
            chk(elems_per_reg == 7'(exp_elems), "R4 elems kept", elems_per_reg, exp_elems);
            @(negedge clk);
            chk(illegal == 1'b0, "R4 single pulse", illegal, 0);
            chk(uop_valid == 1'b0, "R4 still no uop", uop_valid, 0);
            return;
        end
        exp_elems = calc_elems(w);
        chk(elems_per_reg == 7'(exp_elems), "R8 elems", elems_per_reg, exp_elems);
        chk(uop_valid == 1'b1, "R2 first uop next cycle", uop_valid, 1);
        while (k < n && guard < 400) begin
            guard++;
            chk(uop_valid == 1'b1, "R2 uop valid", uop_valid, 1);
            chk(in_ready == 1'b0, "R7 busy", in_ready, 0);
            chk(uop_vd == 5'(vd + k), "R3 vd", uop_vd, vd + k);
            chk(uop_vs1 == 5'(a + k), "R3 vs1", uop_vs1, a + k);
            chk(uop_vs2 == 5'(b + k), "R3 vs2", uop_vs2, b + k);
            chk(uop_last == (k == n - 1), "R5 last flag", uop_last, k == n - 1);
            uop_ready = (($urandom % 100) < ready_pct);
            @(negedge clk);
            if (uop_ready) k++;
            else chk(uop_vd == 5'(vd + k), "R6 held on stall", uop_vd, vd + k);
        end
        uop_ready = 1'b0;
        chk(guard < 400, "R2 sweep finished", guard, n);
        chk(uop_valid == 1'b0, "R5 done after last", uop_valid, 0);
        chk(in_ready == 1'b1, "R7 ready after last", in_ready, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(uop_valid == 1'b0, "R1 reset valid", uop_valid, 0);
        chk(illegal == 1'b0, "R1 reset illegal", illegal, 0);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        chk(elems_per_reg == 7'(VLEN / 8), "R1 reset elems", elems_per_reg, VLEN / 8);

        // Directed corner cases
        run_instr(24, 8, 0, 3, 2, 100);   // R2 group of 8, top group
        run_instr(31, 30, 29, 0, 3, 100); // R2 single register, highest index
        run_instr(3, 4, 6, 1, 1, 100);    // R4 misaligned destination
        run_instr(16, 8, 12, 3, 0, 100);  // R4 misaligned second source only
        run_instr(4, 0, 8, 2, 1, 0 + 40); // R6 heavy stalls
        run_instr(2, 6, 14, 1, 0, 100);   // R8 width 8 again

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            int m = $urandom % 4;
            int n = 1 << m;
            int vd = ($urandom % (32 / n)) * n;
            int a  = ($urandom % (32 / n)) * n;
            int b  = ($urandom % (32 / n)) * n;
            if (m != 0 && ($urandom % 5) == 0) a = a + 1;
            run_instr(vd, a, b, m, $urandom % 4, 70);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=100000 expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule